// File: doc/BRIEF.md
# Secure-Partitioned Retained Register Bank

This block keeps a small bank of retained 32-bit registers that software on either side of a security boundary reads and writes over a single-cycle register port. Each access carries a secure or non-secure attribute. A run-time programmable border index splits the bank. Registers whose index lies below the border answer only to secure accesses. Registers at or above the border are open to both worlds. Only a secure write may move the border.

A tamper pulse wipes every register in the bank. The contents survive the ordinary system reset, so state stored before a warm restart is still there afterwards. A separate power-on reset clears the data. Both resets return the border to its default of 10.

Top module: `bkp_secure_bank`

## Requirements
- R1: After power-on reset every register reads as zero, `border_o` is 10 and `err_o` is 0.
- R2: A secure access (`sec_i`=1) reads and writes any index whatever the border value, and raises no error.
- R3: A non-secure access to an index greater than or equal to `border_o` reads and writes normally with `err_o`=0.
- R4: A non-secure read of an index below `border_o` returns zero on `rdata_o` and sets `err_o` for the single cycle that follows the request. `err_o` returns to 0 after a cycle with no request and no border write.
- R5: A non-secure write to an index below `border_o` leaves the register unchanged and sets `err_o`.
- R6: A secure border write (`brd_we_i`=1, `brd_sec_i`=1) loads `brd_val_i` into the border one cycle later. Values above 32 are clamped to 32.
- R7: A non-secure border write leaves the border unchanged and sets `err_o`.
- R8: Border 0 makes every register non-secure. Border 32 makes every register secure-only.
- R9: `tamper_i` clears all registers at the next edge, overriding a write in the same cycle. Reads issued from the following cycle onward return zero.
- R10: The system reset `rst_ni` returns the border to 10 and keeps register contents. Only `por_ni` or a tamper clears the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset; resets the border and the outputs |
| por_ni | input | 1 | Active-low asynchronous power-on reset; also clears the data |
| tamper_i | input | 1 | Tamper pulse; clears the whole bank |
| req_i | input | 1 | Access request for the register port |
| we_i | input | 1 | 1 = write, 0 = read |
| sec_i | input | 1 | Secure attribute of the access |
| addr_i | input | 5 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, valid the cycle after the request; zero otherwise |
| err_o | output | 1 | Access violation flag, registered |
| brd_we_i | input | 1 | Border write strobe |
| brd_sec_i | input | 1 | Secure attribute of the border write |
| brd_val_i | input | 6 | New border value |
| border_o | output | 6 | Current border value |

## Verification
The assertions watch several properties on every cycle. A denied non-secure read must produce zero data and the error flag. A secure access must never flag an error. A storage array without an accepted write must hold its contents. A tamper must leave the array at zero. Border loads, clamping and dropped non-secure border writes are also checked cycle by cycle. Other behaviour shows only in the bench's scenarios. These cover data retained across the system reset, the border moved to 0 and to 32 with the access map following it, a tamper racing a secure write, and data written before a denied write still reading back intact.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  localparam int unsigned BKP_NUM_DEF    = 32;
  localparam int unsigned BKP_DATA_W_DEF = 32;
  localparam int unsigned BKP_BORDER_DEF = 10;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_OK   = 2'd1,
    ACC_DENY = 2'd2
  } acc_verdict_e;
endpackage

// File: rtl/bkp_border.sv
module bkp_border #(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned BORDER_RST = 10,
  parameter int unsigned BW         = $clog2(NUM_REGS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sec_i,
  input  logic [BW-1:0] val_i,
  output logic [BW-1:0] border_o,
  output logic          deny_o
);
  localparam logic [BW-1:0] MaxVal = BW'(NUM_REGS);
  localparam logic [BW-1:0] RstVal = BW'(BORDER_RST);

  logic [BW-1:0] border_q;
  logic [BW-1:0] clamped;

  assign clamped = (val_i > MaxVal) ? MaxVal : val_i;
  assign deny_o  = we_i && !sec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          border_q <= RstVal;
    else if (we_i && sec_i) border_q <= clamped;
  end

  assign border_o = border_q;

  AST_BRD_NS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sec_i) |=> $stable(border_q)); // R7
  AST_BRD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sec_i && val_i <= MaxVal) |=> border_q == $past(val_i)); // R6
  AST_BRD_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sec_i && val_i > MaxVal) |=> border_q == MaxVal); // R6
endmodule

// File: rtl/bkp_access_check.sv
module bkp_access_check
  import bkp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS),
  parameter int unsigned BW       = $clog2(NUM_REGS + 1)
) (
  input  logic          req_i,
  input  logic          sec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] border_i,
  output acc_verdict_e  verdict_o
);
  logic in_secure_zone;

  assign in_secure_zone = BW'(addr_i) < border_i;

  always_comb begin
    if (!req_i)                         verdict_o = ACC_IDLE;
    else if (sec_i || !in_secure_zone)  verdict_o = ACC_OK;
    else                                verdict_o = ACC_DENY;
  end
endmodule

// File: rtl/bkp_reg_array.sv
module bkp_reg_array #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [NUM_REGS-1:0][DW-1:0] mem_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (addr_i == AW'(g));
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)    mem_q[g] <= '0;
      else if (clr_i) mem_q[g] <= '0;
      else if (hit)   mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == AW'(i)) rdata_o = mem_q[i];
  end

  AST_TAMPER_CLR: assert property (@(posedge clk_i) disable iff (!por_ni)
    clr_i |=> mem_q == '0); // R9
  AST_NO_WR_HOLD: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!we_i && !clr_i) |=> $stable(mem_q)); // R5
endmodule

// File: rtl/bkp_secure_bank.sv
module bkp_secure_bank
  import bkp_pkg::*;
#(
  parameter int unsigned NUM_REGS   = BKP_NUM_DEF,
  parameter int unsigned DATA_W     = BKP_DATA_W_DEF,
  parameter int unsigned BORDER_RST = BKP_BORDER_DEF,
  localparam int unsigned AW        = $clog2(NUM_REGS),
  localparam int unsigned BW        = $clog2(NUM_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              tamper_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sec_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              brd_we_i,
  input  logic              brd_sec_i,
  input  logic [BW-1:0]     brd_val_i,
  output logic [BW-1:0]     border_o
);
  logic              sys_rst_n;
  logic [BW-1:0]     border;
  logic              brd_deny;
  acc_verdict_e      verdict;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  // border and outputs fall back on either reset; data only on power-on
  assign sys_rst_n = rst_ni & por_ni;

  bkp_border #(
    .NUM_REGS  (NUM_REGS),
    .BORDER_RST(BORDER_RST),
    .BW        (BW)
  ) u_border (
    .clk_i   (clk_i),
    .rst_ni  (sys_rst_n),
    .we_i    (brd_we_i),
    .sec_i   (brd_sec_i),
    .val_i   (brd_val_i),
    .border_o(border),
    .deny_o  (brd_deny)
  );

  bkp_access_check #(
    .NUM_REGS(NUM_REGS),
    .AW      (AW),
    .BW      (BW)
  ) u_check (
    .req_i    (req_i),
    .sec_i    (sec_i),
    .addr_i   (addr_i),
    .border_i (border),
    .verdict_o(verdict)
  );

  assign arr_we = we_i && (verdict == ACC_OK);

  bkp_reg_array #(
    .NUM_REGS(NUM_REGS),
    .DW      (DATA_W),
    .AW      (AW)
  ) u_array (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .clr_i  (tamper_i),
    .we_i   (arr_we),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (verdict == ACC_OK && !we_i) ? arr_rdata : '0;
      err_q   <= (verdict == ACC_DENY) || brd_deny;
    end
  end

  assign rdata_o  = rdata_q;
  assign err_o    = err_q;
  assign border_o = border;

  AST_NS_RD_DENY: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (req_i && !we_i && !sec_i && (BW'(addr_i) < border_o)) |=> (err_o && rdata_o == '0)); // R4
  AST_SEC_NO_ERR: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (req_i && sec_i && !(brd_we_i && !brd_sec_i)) |=> !err_o); // R2
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (!req_i && !brd_we_i) |=> !err_o); // R4
  AST_NS_OPEN_OK: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (req_i && !sec_i && (BW'(addr_i) >= border_o) && !brd_we_i) |=> !err_o); // R3
endmodule

// File: tb/bkp_secure_bank_tb_top.sv
module bkp_secure_bank_tb_top;
  localparam int N  = 32;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int BW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, por_n = 1'b0, tamper = 1'b0;
  logic req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic err;
  logic brd_we = 1'b0, brd_sec = 1'b0;
  logic [BW-1:0] brd_val = '0;
  logic [BW-1:0] border;

  bkp_secure_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tamper_i(tamper),
    .req_i(req), .we_i(we), .sec_i(sec), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .brd_we_i(brd_we), .brd_sec_i(brd_sec),
    .brd_val_i(brd_val), .border_o(border)
  );

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    logic [BW-1:0] brd;
    bit            chk;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int total = 0;
  int bad = 0;
  logic [DW-1:0] ref_mem [N];
  int ref_brd = 10;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops the item issued before this edge, compares just after it
  always @(posedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      #1;
      if (cur.chk) begin
        check(rdata == cur.rdata, cur.tag, "rdata", rdata, cur.rdata);
        check(err == cur.err, cur.tag, "err", err, cur.err);
        check(border == cur.brd, cur.tag, "border", border, cur.brd);
      end
    end
  end

  task automatic op(bit r, bit w, bit s, int a, logic [DW-1:0] d,
                    bit bwe, bit bsec, int bval, bit tmp, bit chk, string tag);
    exp_t e;
    bit ok;
    @(negedge clk);
    req = r; we = w; sec = s; addr = AW'(a); wdata = d;
    brd_we = bwe; brd_sec = bsec; brd_val = BW'(bval); tamper = tmp;
    ok = s || (a >= ref_brd);
    e.err   = (r && !ok) || (bwe && !bsec);
    e.rdata = (r && !w && ok) ? ref_mem[a] : '0;
    if (tmp) for (int i = 0; i < N; i++) ref_mem[i] = '0;
    else if (r && w && ok) ref_mem[a] = d;
    if (bwe && bsec) ref_brd = (bval > N) ? N : bval;
    e.brd = BW'(ref_brd);
    e.chk = chk;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(bit s, int a, string tag);
    op(1, 0, s, a, '0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic wr(bit s, int a, logic [DW-1:0] d, string tag);
    op(1, 1, s, a, d, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic bwr(bit s, int v, string tag);
    op(0, 0, 0, 0, '0, 1, s, v, 0, 1, tag);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, '0, 0, 0, 0, 0, 1, tag);
    @(negedge clk);
    req = 0; we = 0; brd_we = 0; tamper = 0;
    @(negedge clk);
  endtask

  task automatic do_reset(bit power, string tag);
    idle(1, tag);
    if (power) begin por_n = 0; for (int i = 0; i < N; i++) ref_mem[i] = '0; end
    else rst_n = 0;
    ref_brd = 10;
    @(negedge clk);
    check(border == 6'd10, tag, "border in reset", border, 10);
    check(err == 1'b0, tag, "err in reset", err, 0);
    check(rdata == '0, tag, "rdata in reset", rdata, 0);
    por_n = 1; rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return (32'hA5C3_0000 ^ (i * 32'h0101_0101)) + i;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    do_reset(1, "R1");
    // R1: bank reads zero after power-on
    for (int i = 0; i < N; i++) rd(1, i, "R1");
    // R2: secure fills and reads every index with border at 10
    for (int i = 0; i < N; i++) wr(1, i, pat(i), "R2");
    for (int i = 0; i < N; i++) rd(1, i, "R2");
    // R3: non-secure open zone
    rd(0, 10, "R3"); rd(0, 31, "R3"); wr(0, 20, 32'h1234_5678, "R3"); rd(0, 20, "R3");
    // R4: denied non-secure reads, then error drops
    rd(0, 9, "R4"); rd(0, 0, "R4"); idle(1, "R4");
    // R5: denied write keeps old data
    wr(0, 3, 32'hDEAD_BEEF, "R5"); rd(1, 3, "R5"); wr(0, 9, 32'h0, "R5"); rd(1, 9, "R5");
    // R7: non-secure border write dropped
    bwr(0, 0, "R7"); rd(0, 5, "R7");
    // R6: secure border loads and clamps
    bwr(1, 40, "R6"); bwr(1, 63, "R6"); bwr(1, 5, "R6"); rd(0, 5, "R6"); rd(0, 4, "R6");
    // R8: extreme borders
    bwr(1, 32, "R8"); rd(0, 31, "R8"); wr(0, 31, 32'h0BAD_0BAD, "R8"); rd(1, 31, "R8");
    bwr(1, 0, "R8"); rd(0, 0, "R8"); wr(0, 0, 32'hCAFE_0000, "R8"); rd(0, 0, "R8");
    idle(1, "R8");
    // R10: system reset keeps data, restores border
    do_reset(0, "R10");
    rd(1, 0, "R10"); rd(1, 3, "R10"); rd(1, 20, "R10"); rd(0, 9, "R10"); rd(0, 10, "R10");
    // R9: tamper beats a same-cycle secure write
    op(1, 1, 1, 7, 32'h7777_7777, 0, 0, 0, 1, 1, "R9");
    for (int i = 0; i < N; i++) rd(1, i, "R9");
    // R1: power-on reset clears freshly written data
    wr(1, 12, 32'h5555_AAAA, "R1"); rd(0, 12, "R1");
    do_reset(1, "R1");
    rd(1, 12, "R1");
    idle(2, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule